// File: doc/BRIEF.md
# Miscellaneous Configuration Register with Interrupt Pin Driver

This block holds a small set of configuration flags for a network controller and drives the pins that depend on them. The flags are a loopback-pass enable, a write enable for the on-chip station-address RAM, an interrupt signalling select (edge or level), a receive-status interface select and an auto-wake enable. The register sits on a 32-bit bus. Its flag bits keep fixed positions in the word because host software decodes them. It can be loaded either by a bus write or by a one-cycle preload strobe from the serial configuration memory reader. The preload wins when both arrive in the same cycle.

The interrupt select sets how both interrupt pins are driven from their internal requests. In edge mode the pin is push-pull and active high. In level mode the pin is active low and open drain, so several devices can share it behind a pull-up. The receive-status select takes three LED pins away from their LED functions and turns them into a raw receive-status interface. It also turns the second interrupt pin into an input that carries an external address-reject indication. Only the hard reset clears the flags. Soft reset and stop leave them untouched.

Top module: `misc_cfg_intr`

## Requirements
- R1: While hard reset (`hard_rst_n` low) is asserted, and after it is released, every flag reads 0. `rd_data` is then 0.
- R2: `rd_data[31:16]`, `rd_data[15]`, `rd_data[13:9]`, `rd_data[6:4]` and `rd_data[1:0]` always read 0. Writing ones to those bits changes no output.
- R3: A bus write (`wr_en` high at a clock edge) loads the flags from `wr_data`. The bit positions are: loopback-pass at 14, address-RAM write enable at 8, interrupt level select at 7, receive-status select at 3 and auto-wake at 2. Each flag reads back at the same position from the next cycle on.
- R4: `lbk_pass_o` is high only when bit 14 is set and `tp_port_sel` is high.
- R5: With bit 7 at 0 (edge mode), `int_oe` is 1 and `int_o` equals `irq_req`.
- R6: With bit 7 at 1 (level mode), `int_o` is 0 and `int_oe` equals `irq_req`, so the pin floats when no request is pending.
- R7: With bit 3 at 1, `led1_o` carries `rx_sfbd`, `led2_o` carries `rx_clk` and `led3_o` carries `rx_data`. With bit 3 at 0, those pins carry `led1_fn`, `led2_fn` and `led3_fn`. `lnk_o` always carries `lnk_fn`.
- R8: With bit 3 at 1, `int2_oe` and `int2_o` are 0 and `addr_rej_o` equals `int2_pin_i`. With bit 3 at 0, `addr_rej_o` is 0 and the second pin is driven from `int2_req` under the rules of R5 and R6.
- R9: A preload strobe (`ee_load`) loads the flags from `ee_data` at the same bit positions as R3. When `ee_load` and `wr_en` are both high at one edge, the preload value is kept.
- R10: `soft_rst` and `stop` change no flag.
- R11: `ram_wr_allow_o` follows bit 8 and `auto_wake_o` follows bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Soft reset request (no effect on flags) |
| stop | input | 1 | Stop request (no effect on flags) |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 32 | Bus write data |
| ee_load | input | 1 | Preload strobe from the configuration memory reader |
| ee_data | input | 16 | Preload data |
| rd_data | output | 32 | Register read value |
| tp_port_sel | input | 1 | Twisted-pair port is the selected attachment |
| lbk_pass_o | output | 1 | Let external loopback frames onto the wire |
| ram_wr_allow_o | output | 1 | Address-RAM writes of 16/32 bits allowed |
| auto_wake_o | output | 1 | Auto-wake enable |
| irq_req | input | 1 | Internal interrupt request, first pin |
| int_o | output | 1 | First interrupt pin data |
| int_oe | output | 1 | First interrupt pin output enable |
| int2_req | input | 1 | Internal interrupt request, second pin |
| int2_pin_i | input | 1 | Level sensed on the second interrupt pin |
| int2_o | output | 1 | Second interrupt pin data |
| int2_oe | output | 1 | Second interrupt pin output enable |
| addr_rej_o | output | 1 | External address-reject indication |
| led1_fn | input | 1 | LED1 function drive |
| led2_fn | input | 1 | LED2 function drive |
| led3_fn | input | 1 | LED3 function drive |
| lnk_fn | input | 1 | Link-status LED function drive |
| rx_sfbd | input | 1 | Receive start-frame-byte-delimiter status |
| rx_clk | input | 1 | Receive clock status |
| rx_data | input | 1 | Receive data status |
| led1_o | output | 1 | LED1 pin |
| led2_o | output | 1 | LED2 pin |
| led3_o | output | 1 | LED3 pin |
| lnk_o | output | 1 | Link-status LED pin |

## Verification
Some rules hold on every cycle, and the assertions check those. They cover the zero reserved bits, the pin drive in each interrupt mode, the gating of loopback by the port select, and the fact that a preload shows up on the next cycle. They also cover flags holding steady through soft reset and stop when nothing loads them. Other behaviour only shows up over a run: the order of writes and preloads, a preload colliding with a write, a hard reset in the middle of a run, and the remap switching back and forth while the receive-status inputs move. The bench's scenarios cover these, comparing every output with its model on each cycle.

// File: rtl/misc_cfg_pkg.sv
package misc_cfg_pkg;

    localparam int BUS_W    = 32;
    localparam int EE_W     = 16;
    localparam int BIT_LBK  = 14;
    localparam int BIT_RAMW = 8;
    localparam int BIT_LVL  = 7;
    localparam int BIT_RSTS = 3;
    localparam int BIT_AWK  = 2;

    typedef struct packed {
        logic lbk_pass;
        logic ram_wr;
        logic level;
        logic rx_stat;
        logic awake;
    } cfg_t;

    function automatic cfg_t cfg_from_word(input logic [EE_W-1:0] w);
        cfg_t c;
        c.lbk_pass = w[BIT_LBK];
        c.ram_wr   = w[BIT_RAMW];
        c.level    = w[BIT_LVL];
        c.rx_stat  = w[BIT_RSTS];
        c.awake    = w[BIT_AWK];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] cfg_to_word(input cfg_t c);
        logic [BUS_W-1:0] w;
        w           = '0;
        w[BIT_LBK]  = c.lbk_pass;
        w[BIT_RAMW] = c.ram_wr;
        w[BIT_LVL]  = c.level;
        w[BIT_RSTS] = c.rx_stat;
        w[BIT_AWK]  = c.awake;
        return w;
    endfunction

endpackage

// File: rtl/misc_cfg_store.sv
module misc_cfg_store
    import misc_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             hard_rst_n,
    input  logic             wr_en,
    input  logic [EE_W-1:0]  wr_low,
    input  logic             ee_load,
    input  logic [EE_W-1:0]  ee_data,
    output cfg_t             cfg_q
);
    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (ee_load) begin
            cfg_d = cfg_from_word(ee_data);
        end else if (wr_en) begin
            cfg_d = cfg_from_word(wr_low);
        end
    end

    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/misc_cfg_irq_drv.sv
module misc_cfg_irq_drv (
    input  logic level_mode,
    input  logic drive_en,
    input  logic req,
    output logic pin_o,
    output logic pin_oe
);
    always_comb begin
        pin_o  = 1'b0;
        pin_oe = 1'b0;
        if (drive_en) begin
            if (level_mode) begin
                pin_o  = 1'b0;
                pin_oe = req;
            end else begin
                pin_o  = req;
                pin_oe = 1'b1;
            end
        end
    end
endmodule

// File: rtl/misc_cfg_pin_mux.sv
module misc_cfg_pin_mux #(
    parameter int N_REMAP = 3
) (
    input  logic               stat_sel,
    input  logic [N_REMAP-1:0] led_fn,
    input  logic [N_REMAP-1:0] stat_src,
    input  logic               lnk_fn,
    input  logic               int2_pin_i,
    output logic [N_REMAP-1:0] led_pin,
    output logic               lnk_pin,
    output logic               addr_rej
);
    for (genvar i = 0; i < N_REMAP; i++) begin : g_led
        logic fn_gated;
        assign fn_gated   = led_fn[i] & ~stat_sel;
        assign led_pin[i] = stat_sel ? stat_src[i] : fn_gated;
    end

    assign lnk_pin  = lnk_fn;
    assign addr_rej = stat_sel & int2_pin_i;
endmodule

// File: rtl/misc_cfg_intr.sv
module misc_cfg_intr
    import misc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              hard_rst_n,
    input  logic              soft_rst,
    input  logic              stop,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              ee_load,
    input  logic [EE_W-1:0]   ee_data,
    output logic [BUS_W-1:0]  rd_data,
    input  logic              tp_port_sel,
    output logic              lbk_pass_o,
    output logic              ram_wr_allow_o,
    output logic              auto_wake_o,
    input  logic              irq_req,
    output logic              int_o,
    output logic              int_oe,
    input  logic              int2_req,
    input  logic              int2_pin_i,
    output logic              int2_o,
    output logic              int2_oe,
    output logic              addr_rej_o,
    input  logic              led1_fn,
    input  logic              led2_fn,
    input  logic              led3_fn,
    input  logic              lnk_fn,
    input  logic              rx_sfbd,
    input  logic              rx_clk,
    input  logic              rx_data,
    output logic              led1_o,
    output logic              led2_o,
    output logic              led3_o,
    output logic              lnk_o
);
    localparam int N_IRQ   = 2;
    localparam int N_REMAP = 3;

    cfg_t             cfg_q;
    logic [N_IRQ-1:0] irq_vec;
    logic [N_IRQ-1:0] irq_en;
    logic [N_IRQ-1:0] pin_o_vec;
    logic [N_IRQ-1:0] pin_oe_vec;
    logic [N_REMAP-1:0] led_pins;

    misc_cfg_store u_store (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .wr_en      (wr_en),
        .wr_low     (wr_data[EE_W-1:0]),
        .ee_load    (ee_load),
        .ee_data    (ee_data),
        .cfg_q      (cfg_q)
    );

    assign irq_vec = {int2_req, irq_req};
    assign irq_en  = {~cfg_q.rx_stat, 1'b1};

    for (genvar p = 0; p < N_IRQ; p++) begin : g_irq
        misc_cfg_irq_drv u_drv (
            .level_mode (cfg_q.level),
            .drive_en   (irq_en[p]),
            .req        (irq_vec[p]),
            .pin_o      (pin_o_vec[p]),
            .pin_oe     (pin_oe_vec[p])
        );
    end

    misc_cfg_pin_mux #(.N_REMAP(N_REMAP)) u_mux (
        .stat_sel   (cfg_q.rx_stat),
        .led_fn     ({led3_fn, led2_fn, led1_fn}),
        .stat_src   ({rx_data, rx_clk, rx_sfbd}),
        .lnk_fn     (lnk_fn),
        .int2_pin_i (int2_pin_i),
        .led_pin    (led_pins),
        .lnk_pin    (lnk_o),
        .addr_rej   (addr_rej_o)
    );

    assign {led3_o, led2_o, led1_o} = led_pins;
    assign int_o          = pin_o_vec[0];
    assign int_oe         = pin_oe_vec[0];
    assign int2_o         = pin_o_vec[1];
    assign int2_oe        = pin_oe_vec[1];
    assign rd_data        = cfg_to_word(cfg_q);
    assign lbk_pass_o     = cfg_q.lbk_pass & tp_port_sel;
    assign ram_wr_allow_o = cfg_q.ram_wr;
    assign auto_wake_o    = cfg_q.awake;
endmodule

// File: rtl/misc_cfg_intr_chk.sv
module misc_cfg_intr_chk
    import misc_cfg_pkg::*;
(
    input logic              clk,
    input logic              hard_rst_n,
    input logic              soft_rst,
    input logic              stop,
    input logic              wr_en,
    input logic              ee_load,
    input logic [EE_W-1:0]   ee_data,
    input logic [BUS_W-1:0]  rd_data,
    input logic              tp_port_sel,
    input logic              lbk_pass_o,
    input logic              irq_req,
    input logic              int_o,
    input logic              int_oe,
    input logic              int2_oe,
    input logic              addr_rej_o
);
    localparam logic [BUS_W-1:0] DEF_MASK =
        (32'h1 << BIT_LBK) | (32'h1 << BIT_RAMW) | (32'h1 << BIT_LVL) |
        (32'h1 << BIT_RSTS) | (32'h1 << BIT_AWK);

    // R2: reserved bits read as zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (rd_data & ~DEF_MASK) == '0);

    // R4: loopback pass needs the twisted-pair port
    a_r4_lbk_needs_tp: assert property (@(posedge clk) disable iff (!hard_rst_n)
        lbk_pass_o |-> tp_port_sel);

    // R5: edge mode drives push-pull active high
    a_r5_edge_drive: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !rd_data[BIT_LVL] |-> (int_oe && int_o == irq_req));

    // R6: level mode drives low only while a request is pending
    a_r6_level_drive: assert property (@(posedge clk) disable iff (!hard_rst_n)
        rd_data[BIT_LVL] |-> (!int_o && int_oe == irq_req));

    // R8: second pin is an input in status mode
    a_r8_int2_input: assert property (@(posedge clk) disable iff (!hard_rst_n)
        rd_data[BIT_RSTS] |-> !int2_oe);

    // R8: no address reject outside status mode
    a_r8_no_reject: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !rd_data[BIT_RSTS] |-> !addr_rej_o);

    // R9: preload lands on the next cycle
    a_r9_preload: assert property (@(posedge clk) disable iff (!hard_rst_n)
        ee_load |=> rd_data == ({16'h0, $past(ee_data)} & DEF_MASK));

    // R10: soft reset and stop leave the flags alone
    a_r10_soft_hold: assert property (@(posedge clk) disable iff (!hard_rst_n)
        ((soft_rst || stop) && !wr_en && !ee_load) |=> $stable(rd_data));
endmodule

bind misc_cfg_intr misc_cfg_intr_chk u_chk (
    .clk         (clk),
    .hard_rst_n  (hard_rst_n),
    .soft_rst    (soft_rst),
    .stop        (stop),
    .wr_en       (wr_en),
    .ee_load     (ee_load),
    .ee_data     (ee_data),
    .rd_data     (rd_data),
    .tp_port_sel (tp_port_sel),
    .lbk_pass_o  (lbk_pass_o),
    .irq_req     (irq_req),
    .int_o       (int_o),
    .int_oe      (int_oe),
    .int2_oe     (int2_oe),
    .addr_rej_o  (addr_rej_o)
);

// File: tb/misc_cfg_intr_test.sv
`timescale 1ns/1ps
module misc_cfg_intr_test;
    logic clk = 1'b0;
    logic hard_rst_n = 1'b0;
    logic soft_rst = 0, stop = 0, wr_en = 0, ee_load = 0;
    logic [31:0] wr_data = '0;
    logic [15:0] ee_data = '0;
    logic [31:0] rd_data;
    logic tp_port_sel = 0, irq_req = 0, int2_req = 0, int2_pin_i = 0;
    logic led1_fn = 0, led2_fn = 0, led3_fn = 0, lnk_fn = 0;
    logic rx_sfbd = 0, rx_clk = 0, rx_data = 0;
    logic lbk_pass_o, ram_wr_allow_o, auto_wake_o, int_o, int_oe;
    logic int2_o, int2_oe, addr_rej_o, led1_o, led2_o, led3_o, lnk_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [15:0] model = '0;
    localparam logic [15:0] MASK = 16'h418C;

    always #2.5 clk = ~clk;

    misc_cfg_intr uut (.*);

    // behavioural model of the flag word
    always @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n)   model <= '0;
        else if (ee_load)  model <= ee_data & MASK;
        else if (wr_en)    model <= wr_data[15:0] & MASK;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic lvl, rs;
        lvl = model[7];
        rs  = model[3];
        chk("R1", "rd_data", rd_data, {16'h0, model});
        chk("R2", "reserved", rd_data & ~{16'h0, MASK}, 32'h0);
        chk("R4", "lbk_pass", lbk_pass_o, model[14] & tp_port_sel);
        chk("R11", "ram_wr", ram_wr_allow_o, model[8]);
        chk("R11", "awake", auto_wake_o, model[2]);
        if (!lvl) begin
            chk("R5", "int_o", int_o, irq_req);
            chk("R5", "int_oe", int_oe, 1'b1);
        end else begin
            chk("R6", "int_o", int_o, 1'b0);
            chk("R6", "int_oe", int_oe, irq_req);
        end
        chk("R7", "led1", led1_o, rs ? rx_sfbd : led1_fn);
        chk("R7", "led2", led2_o, rs ? rx_clk : led2_fn);
        chk("R7", "led3", led3_o, rs ? rx_data : led3_fn);
        chk("R7", "lnk", lnk_o, lnk_fn);
        if (rs) begin
            chk("R8", "int2_oe", int2_oe, 1'b0);
            chk("R8", "int2_o", int2_o, 1'b0);
            chk("R8", "addr_rej", addr_rej_o, int2_pin_i);
        end else begin
            chk("R8", "addr_rej", addr_rej_o, 1'b0);
            chk("R8", "int2_o", int2_o, lvl ? 1'b0 : int2_req);
            chk("R8", "int2_oe", int2_oe, lvl ? int2_req : 1'b1);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic rand_pins();
        {tp_port_sel, irq_req, int2_req, int2_pin_i} = 4'($urandom);
        {led1_fn, led2_fn, led3_fn, lnk_fn} = 4'($urandom);
        {rx_sfbd, rx_clk, rx_data} = 3'($urandom);
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #12;
        @(negedge clk);
        compare_all();
        chk("R1", "reset rd", rd_data, 32'h0);
        hard_rst_n = 1'b1;
        step();

        // R2, R3: all ones write, reserved stays zero
        wr_en = 1; wr_data = 32'hFFFF_FFFF;
        step();
        wr_en = 0;
        chk("R3", "all ones", rd_data, 32'h0000_418C);
        for (int i = 0; i < 16; i++) begin rand_pins(); step(); end

        // R3: single flags
        wr_en = 1; wr_data = 32'h0000_0080; step();
        chk("R3", "level only", rd_data, 32'h80);
        wr_data = 32'hABCD_0008; step();
        chk("R3", "remap only", rd_data, 32'h8);
        wr_en = 0;
        for (int i = 0; i < 16; i++) begin rand_pins(); step(); end

        // R9: preload beats a write in the same cycle
        wr_en = 1; wr_data = 32'h0000_4104; ee_load = 1; ee_data = 16'h0088;
        step();
        chk("R9", "collision", rd_data, 32'h88);
        wr_en = 0; ee_load = 0;

        // R10: soft reset and stop keep flags
        soft_rst = 1; step(); step();
        soft_rst = 0; stop = 1; step();
        stop = 0;
        chk("R10", "after soft", rd_data, 32'h88);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            wr_en    = ($urandom % 4) == 0;
            ee_load  = ($urandom % 7) == 0;
            wr_data  = $urandom;
            ee_data  = 16'($urandom);
            soft_rst = ($urandom % 5) == 0;
            stop     = ($urandom % 5) == 0;
            rand_pins();
            step();
            if (i == 1500) begin
                // R1: hard reset mid-run
                wr_en = 0; ee_load = 0;
                #1 hard_rst_n = 0;
                #1 chk("R1", "async clear", rd_data, 32'h0);
                @(negedge clk);
                hard_rst_n = 1;
                compare_all();
            end
        end
        wr_en = 0; ee_load = 0; soft_rst = 0; stop = 0;
        step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule